// File: doc/BRIEF.md
# Relative Conditional Branch Unit

This block resolves the short relative branches of an 8-bit accumulator processor in a single registered stage. It is given the opcode byte that was just fetched, the operand byte that follows it, the address of the opcode, and the four status flags: negative, overflow, carry and zero. From these it reports whether a branch is taken and which address is fetched next.

The block also spots the break opcode and raises a halt request for it. Any other opcode is marked for hand-off to the general instruction decoder. This decode runs ahead of the general decoder, so that group never sees a branch or a break.

Each accepted request produces one registered result on the following clock edge. While no request is presented, the result outputs keep their last values.

Top module: `cbu_top`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted request, res_valid, res_taken, res_halt and res_pass are 0 and res_next_pc is 0.
- R2: res_valid is 1 in exactly the cycle after a cycle in which req_valid was 1 at the clock edge, and 0 otherwise.
- R3: An opcode whose low five bits are 10000 (0x10, 0x30, 0x50, 0x70, 0x90, 0xB0, 0xD0, 0xF0) is a branch. Every result has at most one of res_taken, res_halt and res_pass set, and a branch result never sets res_halt or res_pass.
- R4: For a branch, opcode bits 7:6 select the flag tested (00 = negative, 01 = overflow, 10 = carry, 11 = zero). The branch is taken when that flag equals opcode bit 5. For example, 0x10 is taken on negative clear, 0xB0 on carry set, 0xD0 on zero clear and 0xF0 on zero set.
- R5: A taken branch gives res_next_pc = req_pc + 2 + the operand read as a signed two's-complement byte.
- R6: A branch that is not taken gives res_next_pc = req_pc + 2, which is the address past the opcode and its single operand byte.
- R7: Opcode 0x00 gives res_halt = 1, res_taken = 0 and res_next_pc = req_pc + 1, whatever the flags are.
- R8: Every other opcode gives res_pass = 1, res_taken = 0 and res_next_pc = req_pc + 1. The flags and the operand have no effect on it.
- R9: All program counter arithmetic wraps modulo 2^PC_W, both forward across the top of the address space and backward below zero.
- R10: In a cycle after one with req_valid low, res_next_pc, res_taken, res_halt and res_pass keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 8 | Fetched opcode byte |
| req_operand | input | 8 | Byte following the opcode |
| req_pc | input | PC_W | Address of the opcode |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| res_valid | output | 1 | Result present |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | PC_W | Next fetch address |
| res_halt | output | 1 | Break seen, stop stepping |
| res_pass | output | 1 | Opcode belongs to the general decoder |

## Verification
The bench builds the block with the default PC_W of 16. At that width it can place the opcode address at 0xFFFE, 0xFFFF and 0x0001, so forward and backward branches cross the ends of the address space and the wrap rule is exercised. Each of the eight branch opcodes is driven with its tested flag both set and clear while the other flags are set against it. This shows that only the selected flag decides the outcome.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [1:0] {
    SEL_NEG = 2'd0,
    SEL_OVF = 2'd1,
    SEL_CRY = 2'd2,
    SEL_ZER = 2'd3
  } flag_sel_e;

  typedef enum logic [1:0] {
    KIND_PASS   = 2'd0,
    KIND_BRANCH = 2'd1,
    KIND_HALT   = 2'd2
  } op_kind_e;

  localparam int unsigned OPC_W   = 8;
  localparam logic [4:0]  BR_LOW  = 5'b10000;
  localparam logic [7:0]  OPC_BRK = 8'h00;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_kind_e         kind,
  output flag_sel_e        sel,
  output logic             want
);
  always_comb begin
    if (opcode[4:0] == BR_LOW)     kind = KIND_BRANCH;
    else if (opcode == OPC_BRK)    kind = KIND_HALT;
    else                           kind = KIND_PASS;
  end

  assign sel  = flag_sel_e'(opcode[7:6]);
  assign want = opcode[5];
endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
  import cbu_pkg::*;
(
  input  flag_sel_e sel,
  input  logic      want,
  input  logic      flag_n,
  input  logic      flag_v,
  input  logic      flag_c,
  input  logic      flag_z,
  output logic      cond_met
);
  logic picked;

  always_comb begin
    unique case (sel)
      SEL_NEG: picked = flag_n;
      SEL_OVF: picked = flag_v;
      SEL_CRY: picked = flag_c;
      default: picked = flag_z;
    endcase
  end

  assign cond_met = (picked == want);
endmodule

// File: rtl/cbu_target.sv
module cbu_target
  import cbu_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  op_kind_e         kind,
  input  logic             cond_met,
  input  logic [PC_W-1:0]  pc,
  input  logic [OPC_W-1:0] operand,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  localparam int unsigned EXT_W = PC_W - OPC_W;

  function automatic logic [PC_W-1:0] sext_off(input logic [OPC_W-1:0] b);
    return {{EXT_W{b[OPC_W-1]}}, b};
  endfunction

  function automatic logic [PC_W-1:0] pc_plus(input logic [PC_W-1:0] p,
                                               input int unsigned n);
    return p + PC_W'(n);
  endfunction

  logic [PC_W-1:0] fall_pc;

  assign fall_pc = pc_plus(pc, 2);
  assign taken   = (kind == KIND_BRANCH) && cond_met;

  always_comb begin
    if (kind != KIND_BRANCH) next_pc = pc_plus(pc, 1);
    else if (cond_met)       next_pc = fall_pc + sext_off(operand);
    else                     next_pc = fall_pc;
  end
endmodule

// File: rtl/cbu_top.sv
module cbu_top
  import cbu_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [7:0]      req_opcode,
  input  logic [7:0]      req_operand,
  input  logic [PC_W-1:0] req_pc,
  input  logic            flag_n,
  input  logic            flag_v,
  input  logic            flag_c,
  input  logic            flag_z,
  output logic            res_valid,
  output logic            res_taken,
  output logic [PC_W-1:0] res_next_pc,
  output logic            res_halt,
  output logic            res_pass
);
  op_kind_e        dec_kind;
  flag_sel_e       dec_sel;
  logic            dec_want;
  logic            cond_met;
  logic            is_branch;
  logic            comb_taken;
  logic [PC_W-1:0] comb_next;

  cbu_decode i_decode (
    .opcode (req_opcode),
    .kind   (dec_kind),
    .sel    (dec_sel),
    .want   (dec_want)
  );

  cbu_cond i_cond (
    .sel      (dec_sel),
    .want     (dec_want),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .cond_met (cond_met)
  );

  cbu_target #(.PC_W(PC_W)) i_target (
    .kind     (dec_kind),
    .cond_met (cond_met),
    .pc       (req_pc),
    .operand  (req_operand),
    .taken    (comb_taken),
    .next_pc  (comb_next)
  );

  assign is_branch = (dec_kind == KIND_BRANCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
      res_halt    <= 1'b0;
      res_pass    <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken   <= comb_taken;
        res_next_pc <= comb_next;
        res_halt    <= (dec_kind == KIND_HALT);
        res_pass    <= (dec_kind == KIND_PASS);
      end
    end
  end
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [7:0]      req_opcode,
  input logic [PC_W-1:0] req_pc,
  input logic            is_branch,
  input logic            res_valid,
  input logic            res_taken,
  input logic [PC_W-1:0] res_next_pc,
  input logic            res_halt,
  input logic            res_pass
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);  // R2
  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);  // R2
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_taken, res_halt, res_pass}));  // R3
  AST_BRANCH_NOT_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_branch) |=> (!res_halt && !res_pass));  // R3
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_branch) ##1 !res_taken
      |-> res_next_pc == $past(req_pc) + PC_W'(2));  // R6
  AST_HALT_ON_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_opcode == 8'h00)
      |=> (res_halt && !res_taken && res_next_pc == $past(req_pc) + PC_W'(1)));  // R7
  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_pass |-> res_next_pc == $past(req_pc) + PC_W'(1));  // R8
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_next_pc) && $stable(res_taken)
                    && $stable(res_halt) && $stable(res_pass)));  // R10
endmodule

bind cbu_top cbu_checker #(.PC_W(PC_W)) i_cbu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_opcode  (req_opcode),
  .req_pc      (req_pc),
  .is_branch   (is_branch),
  .res_valid   (res_valid),
  .res_taken   (res_taken),
  .res_next_pc (res_next_pc),
  .res_halt    (res_halt),
  .res_pass    (res_pass)
);

// File: tb/test_cbu_top.sv
module test_cbu_top;
  localparam int unsigned PC_W = 16;

  typedef struct {
    logic            taken;
    logic [PC_W-1:0] npc;
    logic            halt;
    logic            pass;
    string           tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [7:0] req_opcode = 0, req_operand = 0;
  logic [PC_W-1:0] req_pc = 0;
  logic fn = 0, fv = 0, fc = 0, fz = 0;
  logic res_valid, res_taken, res_halt, res_pass;
  logic [PC_W-1:0] res_next_pc;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  cbu_top #(.PC_W(PC_W)) i_cbu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_opcode(req_opcode), .req_operand(req_operand), .req_pc(req_pc),
    .flag_n(fn), .flag_v(fv), .flag_c(fc), .flag_z(fz),
    .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
    .res_halt(res_halt), .res_pass(res_pass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] off,
                                 input logic [PC_W-1:0] pc,
                                 input logic n, v, c, z);
    exp_t e;
    logic hit;
    int signed d;
    e.taken = 0; e.halt = 0; e.pass = 0;
    e.npc = pc + 1;
    e.tag = "R8";
    case (op)
      8'h00: begin e.halt = 1; e.tag = "R7"; end
      8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0: begin
        case (op)
          8'h10: hit = !n;  8'h30: hit = n;
          8'h50: hit = !v;  8'h70: hit = v;
          8'h90: hit = !c;  8'hB0: hit = c;
          8'hD0: hit = !z;  default: hit = z;
        endcase
        d = (off > 127) ? int'(off) - 256 : int'(off);
        e.taken = hit;
        e.npc = hit ? PC_W'(int'(pc) + 2 + d) : PC_W'(int'(pc) + 2);
        e.tag = hit ? "R4/R5" : "R4/R6";
      end
      default: e.pass = 1;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] off,
                       input logic [PC_W-1:0] pc, input logic [3:0] nvcz);
    @(negedge clk);
    req_valid = 1; req_opcode = op; req_operand = off; req_pc = pc;
    {fn, fv, fc, fz} = nvcz;
    sb.push_back(model(op, off, pc, nvcz[3], nvcz[2], nvcz[1], nvcz[0]));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
    req_opcode = 8'hF0; req_pc = 16'h1234; {fn, fv, fc, fz} = 4'hF;
  endtask

  // monitor: pop and compare, and check hold after idle (R10, R2)
  logic [PC_W-1:0] last_npc = 0;
  logic [2:0] last_kind = 0;
  logic prev_req = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        exp_t e;
        chk("R2 valid with request", 1, prev_req);
        if (sb.size() == 0) begin
          chk("R2 unexpected result", 1, 0);
        end else begin
          e = sb.pop_front();
          chk({e.tag, " taken"}, res_taken, e.taken);
          chk({e.tag, " next_pc"}, res_next_pc, e.npc);
          chk({"R3/", e.tag, " halt"}, res_halt, e.halt);
          chk({"R3/", e.tag, " pass"}, res_pass, e.pass);
        end
      end else if (!prev_req && checks > 0) begin
        chk("R10 hold next_pc", res_next_pc, last_npc);
        chk("R10 hold kind", {res_taken, res_halt, res_pass}, last_kind);
      end
      last_npc = res_next_pc;
      last_kind = {res_taken, res_halt, res_pass};
      prev_req = req_valid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 taken", res_taken, 0);
    chk("R1 halt", res_halt, 0);
    chk("R1 pass", res_pass, 0);
    chk("R1 next_pc", res_next_pc, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {res_valid, res_taken, res_halt, res_pass}, 0);
    // R4: each branch with its flag both ways, other flags set against it
    for (int k = 0; k < 8; k++) begin
      logic [7:0] op = {k[2:0], 5'b10000};
      logic [1:0] s = op[7:6];
      logic [3:0] on  = 4'b1000 >> s;
      drive(op, 8'h10, 16'h0400, on);
      drive(op, 8'hF0, 16'h0400, ~on);
    end
    // R5/R9 wrap forward and backward
    drive(8'hF0, 8'h05, 16'hFFFE, 4'b0001);
    drive(8'h30, 8'h80, 16'h0001, 4'b1000);
    drive(8'h90, 8'h7F, 16'hFFFF, 4'b0000);
    // R6 not taken near the top end
    drive(8'hB0, 8'h40, 16'hFFFF, 4'b0000);
    // R7 break under varying flags
    drive(8'h00, 8'h33, 16'h2000, 4'b1111);
    drive(8'h00, 8'h00, 16'hFFFF, 4'b0000);
    // R8 other opcodes, flags and operand ignored
    drive(8'hA9, 8'h80, 16'h3000, 4'b1111);
    drive(8'h18, 8'h7F, 16'h3000, 4'b0000);
    drive(8'h11, 8'hFF, 16'hFFFF, 4'b1010);
    drive(8'hF1, 8'h01, 16'h0010, 4'b0101);
    drive(8'h01, 8'h22, 16'h0020, 4'b1111);
    // R10 idle gaps
    idle(); idle();
    drive(8'hD0, 8'hFE, 16'h0100, 4'b0000);
    idle(); idle(); idle();
    @(negedge clk);
    chk("R2 scoreboard drained", sb.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule